// File: doc/BRIEF.md
# Write-once watchdog timer

This block is a watchdog with a single write-only control word. The first write after reset configures it and locks the configuration: a 12-bit reload count, a choice of a fixed large prescaler, an enable and a 2-bit action code. After that, a write does one thing only. It reloads the countdown from the stored reload count, and the data it carries is discarded. Software therefore cannot change the timeout or disable a running watchdog. It can only keep it alive by writing before the count runs out.

The countdown advances on a timer tick at half the bus clock rate. That tick is a clock enable that is high on every second bus cycle, so the block has one clock domain. With the prescaler selected, the tick is divided again by `PRESCALE_DIV`. When an enabled count reaches zero, the block raises a sticky expiry output. Action code 2 selects an interrupt, and any other code selects a reset request. The output stays high until the synchronous active-low reset.

Top module: `wdog_lock_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears its lock, count and expiry state. After that edge `irq_o` and `rst_req_o` are both 0, and the next write is treated as a first write.
- R2: The first write after reset captures four fields from `wr_data`: the reload count in bits 11:0, the prescaler select in bit 12, the enable in bit 13 and the action code in bits 15:14. The count is loaded with the reload value in the same edge.
- R3: Any write after the first leaves the reload count, prescaler select, enable and action code unchanged, whatever its data.
- R4: Any write after the first reloads the count from the stored reload value and restarts the tick phase. Expiry timing is then measured from that write.
- R5: With the prescaler off, the count drops by one every 2 bus cycles. The expiry output rises 2*R+1 cycles after the loading write edge, where R is the stored reload value.
- R6: With the prescaler on, the count drops by one every 2*PRESCALE_DIV bus cycles. The expiry output rises 2*PRESCALE_DIV*R+1 cycles after the loading write.
- R7: On expiry, action code 2 raises `irq_o` and any other code raises `rst_req_o`. The two outputs are never high together.
- R8: Once raised, the expiry output stays high until reset. Later writes do not clear it.
- R9: If the enable bit of the first write is 0, the block never expires. A later write with the enable bit set does not start it.
- R10: Reload value 0 expires one cycle after the write. Reload value 4095 expires after the full 8191 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word data |
| irq_o | output | 1 | Sticky expiry interrupt (action code 2) |
| rst_req_o | output | 1 | Sticky expiry reset request (other action codes) |

## Verification
The expiry outputs are the only visible state, so most faults show up as a change in when they rise. A lock flag that fails to hold shows up at the next expiry, which then follows the data of the second write. A divider phase error moves the rising edge by a cycle or more. A wrong count load shifts it by two cycles per unit of error. The bench runs a behavioural model alongside the design and compares both outputs on every cycle. It also measures the exact rise cycle after each loading write, so a timing fault is reported at the first cycle where the outputs diverge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int RELOAD_W = 12;
  localparam int WORD_W   = 16;
  localparam logic [1:0] ACT_IRQ = 2'd2;

  // Field layout of the control word, most significant field first.
  typedef struct packed {
    logic [1:0]          action;
    logic                enable;
    logic                pre_sel;
    logic [RELOAD_W-1:0] reload;
  } wdt_cfg_t;

  function automatic wdt_cfg_t cfg_of(input logic [WORD_W-1:0] word);
    wdt_cfg_t c;
    c = wdt_cfg_t'(word);
    return c;
  endfunction

  function automatic logic is_irq_action(input logic [1:0] act);
    return act == ACT_IRQ;
  endfunction

  function automatic logic [RELOAD_W-1:0] count_down(input logic [RELOAD_W-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

endpackage

// File: rtl/wdt_cfg_lock.sv
module wdt_cfg_lock
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output wdt_cfg_t          cfg,
  output logic              locked,
  output logic              first_wr,
  output logic              restart_wr
);

  assign first_wr   = wr_en && !locked;
  assign restart_wr = wr_en && locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      cfg    <= '0;
    end else if (first_wr) begin
      locked <= 1'b1;
      cfg    <= cfg_of(wr_data);
    end
  end

  // R3
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(cfg)));

endmodule

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
  parameter int PRESCALE_DIV = 16384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pre_sel,
  output logic half_en,
  output logic dec_en
);

  localparam int PW = (PRESCALE_DIV < 2) ? 1 : $clog2(PRESCALE_DIV);
  localparam logic [PW-1:0] PMAX = PW'(PRESCALE_DIV - 1);

  logic          phase;
  logic [PW-1:0] pcnt;
  logic          pre_en;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase <= 1'b0;
      pcnt  <= '0;
    end else begin
      phase <= ~phase;
      if (phase) pcnt <= (pcnt == PMAX) ? '0 : pcnt + 1'b1;
    end
  end

  assign half_en = phase;
  assign pre_en  = phase && (pcnt == PMAX);
  assign dec_en  = pre_sel ? pre_en : half_en;

  // R5
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en |=> !dec_en);

endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount
  import wdt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [RELOAD_W-1:0] load_val,
  input  logic                first_load,
  input  logic                first_en,
  input  logic                dec_en,
  output logic                run,
  output logic                cnt_zero,
  output logic                expired
);

  logic [RELOAD_W-1:0] count;

  assign cnt_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      run     <= 1'b0;
      expired <= 1'b0;
    end else begin
      if (first_load) run <= first_en;
      if (load) begin
        count <= load_val;
      end else if (run && cnt_zero) begin
        expired <= 1'b1;
      end else if (run && dec_en) begin
        count <= count_down(count);
      end
    end
  end

  // R8
  expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> expired);

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && !cnt_zero) |=> ((count == $past(count)) || (count == $past(count) - 1'b1)));

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !first_load) |=> !expired);

endmodule

// File: rtl/wdog_lock_timer.sv
module wdog_lock_timer
  import wdt_pkg::*;
#(
  parameter int PRESCALE_DIV = 16384
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        irq_o,
  output logic        rst_req_o
);

  wdt_cfg_t            cfg;
  wdt_cfg_t            wr_cfg;
  logic                locked;
  logic                first_wr;
  logic                restart_wr;
  logic                load;
  logic [RELOAD_W-1:0] load_val;
  logic                half_en;
  logic                dec_en;
  logic                run;
  logic                cnt_zero;
  logic                expired;

  assign wr_cfg = cfg_of(wr_data);

  wdt_cfg_lock u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cfg        (cfg),
    .locked     (locked),
    .first_wr   (first_wr),
    .restart_wr (restart_wr)
  );

  assign load     = first_wr || restart_wr;
  assign load_val = first_wr ? wr_cfg.reload : cfg.reload;

  wdt_tick_gen #(.PRESCALE_DIV(PRESCALE_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (load),
    .pre_sel (cfg.pre_sel),
    .half_en (half_en),
    .dec_en  (dec_en)
  );

  wdt_downcount u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .load_val   (load_val),
    .first_load (first_wr),
    .first_en   (wr_cfg.enable),
    .dec_en     (dec_en),
    .run        (run),
    .cnt_zero   (cnt_zero),
    .expired    (expired)
  );

  assign irq_o     = expired && is_irq_action(cfg.action);
  assign rst_req_o = expired && !is_irq_action(cfg.action);

  // R7
  one_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));

  // R10
  zero_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_zero && !load) |=> (irq_o || rst_req_o));

  // R2
  lock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> locked);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && !rst_req_o && !locked));

  // R5
  half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_en && !load) |=> !half_en);

endmodule

// File: tb/wdog_lock_timer_tb.sv
module wdog_lock_timer_tb;

  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        irq_o;
  logic        rst_req_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 1'b0;

  // behavioural reference state
  bit m_lock, m_run, m_pre, m_exp;
  int m_cnt, m_rel, m_act, m_ph;

  always #2 clk = ~clk;

  wdog_lock_timer #(.PRESCALE_DIV(D)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .irq_o     (irq_o),
    .rst_req_o (rst_req_o)
  );

  always @(posedge clk) begin
    int step;
    started <= 1'b1;
    cycles  <= cycles + 1;
    step = m_pre ? 2 * D : 2;
    if (!rst_n) begin
      m_lock = 0; m_run = 0; m_pre = 0; m_exp = 0;
      m_cnt = 0; m_rel = 0; m_act = 0; m_ph = 0;
    end else if (wr_en) begin
      if (!m_lock) begin
        m_lock = 1;
        m_rel  = wr_data % 4096;
        m_pre  = wr_data[12];
        m_run  = wr_data[13];
        m_act  = wr_data / 16384;
        m_cnt  = m_rel;
      end else begin
        m_cnt = m_rel;
      end
      m_ph = 0;
    end else begin
      m_ph = m_ph + 1;
      if (m_run && m_cnt == 0) m_exp = 1;
      else if (m_run && (m_ph % step) == 0) m_cnt = m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      bit e_irq, e_rst;
      e_irq = m_exp && (m_act == 2);
      e_rst = m_exp && (m_act != 2);
      checks++;
      if (irq_o !== e_irq || rst_req_o !== e_rst) begin
        errors++;
        $display("FAIL model R7 cycle %0d irq=%b rst_req=%b expected irq=%b rst_req=%b",
                 cycles, irq_o, rst_req_o, e_irq, e_rst);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] mk(input int act, input int en, input int pre, input int rel);
    return {act[1:0], en[0], pre[0], rel[11:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts cycles from the last write edge until an expiry output rises; -1 if none
  task automatic wait_exp(input int limit, output int n);
    n = 0;
    while (!(irq_o || rst_req_o) && n < limit) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
    if (!(irq_o || rst_req_o)) n = -1;
  endtask

  initial begin
    int n;
    do_reset();
    // R1 reset state
    chk(irq_o == 0 && rst_req_o == 0, "R1 outputs after reset", int'(irq_o) + int'(rst_req_o), 0);

    // R2 R5 plain countdown, interrupt action
    wr(mk(2, 1, 0, 5));
    wait_exp(100, n);
    chk(n == 11, "R5 expiry cycle reload 5", n, 11);
    chk(irq_o == 1 && rst_req_o == 0, "R7 action 2 gives irq", int'(irq_o), 1);
    chk(n == 11, "R2 fields captured by first write", n, 11);

    // R7 reset action, R8 sticky, R1 reset clears
    do_reset();
    wr(mk(0, 1, 0, 3));
    wait_exp(100, n);
    chk(n == 7, "R5 expiry cycle reload 3", n, 7);
    chk(rst_req_o == 1 && irq_o == 0, "R7 action 0 gives reset request", int'(rst_req_o), 1);
    wr(mk(2, 1, 0, 100));
    repeat (6) @(negedge clk);
    chk(rst_req_o == 1, "R8 expiry stays after restart write", int'(rst_req_o), 1);
    do_reset();
    chk(irq_o == 0 && rst_req_o == 0, "R1 reset clears expiry", int'(rst_req_o), 0);

    // R3 R4 restart ignores data, reloads stored value
    wr(mk(2, 1, 0, 20));
    repeat (9) @(negedge clk);
    chk(irq_o == 0, "R4 no expiry before restart", int'(irq_o), 0);
    wr(mk(1, 1, 1, 2));
    wait_exp(200, n);
    chk(n == 41, "R4 expiry measured from restart write", n, 41);
    chk(irq_o == 1 && rst_req_o == 0, "R3 action unchanged by later write", int'(irq_o), 1);

    // R9 disabled first write
    do_reset();
    wr(mk(2, 0, 0, 2));
    wait_exp(200, n);
    chk(n == -1, "R9 disabled never expires", n, -1);
    wr(mk(2, 1, 0, 2));
    wait_exp(200, n);
    chk(n == -1, "R9 later enable write cannot start", n, -1);

    // R6 prescaler
    do_reset();
    wr(mk(3, 1, 1, 3));
    wait_exp(500, n);
    chk(n == 2 * D * 3 + 1, "R6 prescaled expiry cycle", n, 2 * D * 3 + 1);
    chk(rst_req_o == 1, "R7 action 3 gives reset request", int'(rst_req_o), 1);

    // R10 boundaries
    do_reset();
    wr(mk(2, 1, 0, 0));
    wait_exp(50, n);
    chk(n == 1, "R10 reload 0 expiry", n, 1);
    do_reset();
    wr(mk(1, 1, 0, 4095));
    wait_exp(10000, n);
    chk(n == 8191, "R10 reload 4095 expiry", n, 8191);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule